// File: doc/BRIEF.md
# Dual Timer Register Block

This peripheral carries two independent counters behind a single-cycle 32-bit register bus. The first is a 56-bit countdown event timer. Software stages the low 32 bits of a delay in a load register. It then writes a control word that carries the upper 24 bits of the delay together with a run enable, a periodic-reload flag and a commit strobe. When the countdown expires, the timer raises a status flag. In periodic mode it reloads the committed delay and keeps running. In single-shot mode it drops its enable. The status flag reaches the interrupt output only through a mask bit, which software sets and clears through two separate write-one addresses. Software clears the status flag by writing a one.

The second counter is a free-running 64-bit up-counter that software reads as two words. A read of the low word captures the upper word into a holding register, so the next read of the upper word matches the low word just returned, even if the counter carried in between. Both counters advance only in cycles where the `tick` input is high. A 2 MHz tick is typical, and the shortest useful event delay is 2 ticks.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset every register (load word, control, mask, status) reads 0 and `irq` is low.
- R2: A write to offset 0x000 stores the low delay word, and it reads back unchanged.
- R3: A write to offset 0x004 stores delay bits 55:32 from data bits 23:0, enable from bit 24 and periodic from bit 28. Readback returns these fields, and bit 30 (commit) reads 0. With bit 30 set, the write loads the 56-bit value {bits 23:0, low word} into the countdown and into the reload register.
- R4: In single-shot mode a committed delay N≥1 expires on the Nth enabled tick. Expiry sets status bit 0 and clears enable, and no further expiry follows.
- R5: In periodic mode the countdown expires every N ticks, reloading the committed value, and enable stays set.
- R6: Writing 0 to the control register stops the countdown, so later ticks cause no expiry.
- R7: Writing a one to bit 0 at offset 0x02C sets the mask, and writing a one to bit 0 at offset 0x030 clears it. A zero in bit 0 changes nothing. A read of either offset returns the mask in bit 0.
- R8: `irq` is high exactly when status bit 0 and mask bit 0 are both 1.
- R9: Status bit 0 reads at offset 0x034. Writing a one to bit 0 there clears it, and writing 0 has no effect. An expiry in the same cycle as a clear leaves the bit set.
- R10: The free counter adds one per tick. A read of offset 0x024 returns its low word and captures its high word. A read of offset 0x028 returns the captured high word.
- R11: Other offsets read as 0, and writes to them change no register.
- R12: Without `tick` neither counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for both counters |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (drives the high-word capture) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Masked event-timer interrupt |

## Verification
The countdown is tried with a short single-shot delay and with a short periodic delay. Sampling the interrupt one tick before and exactly at the expected expiry separates an off-by-one countdown from a correct one. The periodic run separates reload from stop. A long stretch of idle clocks with no tick, followed by a stop write and further ticks, shows that only `tick` and enable move the countdown. Writes of zero to the mask and status addresses, and writes to an unmapped offset, show that the write-one and decode rules leave unrelated state alone. A wide control word shows where the upper delay bits and the flags land.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
   localparam logic [7:0] OFS_LOAD_LO = 8'h00;
   localparam logic [7:0] OFS_CTRL    = 8'h04;
   localparam logic [7:0] OFS_FREE_LO = 8'h24;
   localparam logic [7:0] OFS_FREE_HI = 8'h28;
   localparam logic [7:0] OFS_MSK_SET = 8'h2C;
   localparam logic [7:0] OFS_MSK_CLR = 8'h30;
   localparam logic [7:0] OFS_STAT    = 8'h34;

   localparam int CTRL_HI_MAX  = 24;
   localparam int CTRL_EN_POS  = 24;
   localparam int CTRL_RPT_POS = 28;
   localparam int CTRL_LD_POS  = 30;
endpackage

// File: rtl/dtt_event_counter.sv
module dtt_event_counter #(
   parameter int LO_W  = 32,
   parameter int EVT_W = 56,
   localparam int HI_W = EVT_W - LO_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            lo_we,
   input  logic [LO_W-1:0] lo_wdata,
   input  logic            ctrl_we,
   input  logic [HI_W-1:0] ctrl_hi,
   input  logic            ctrl_en,
   input  logic            ctrl_rpt,
   input  logic            ctrl_ld,
   output logic [LO_W-1:0] lo_q,
   output logic [HI_W-1:0] hi_q,
   output logic            en_q,
   output logic            rpt_q,
   output logic            expire
);
   logic [EVT_W-1:0] count_q;
   logic [EVT_W-1:0] reload_q;
   logic [EVT_W-1:0] commit_val;

   assign commit_val = {ctrl_hi, lo_q};
   // A countdown at 1 (or 0) ends on this tick; a control write takes precedence.
   assign expire = en_q && tick && !ctrl_we && (count_q <= EVT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q     <= '0;
         hi_q     <= '0;
         en_q     <= 1'b0;
         rpt_q    <= 1'b0;
         count_q  <= '0;
         reload_q <= '0;
      end else begin
         if (lo_we) lo_q <= lo_wdata;
         if (ctrl_we) begin
            hi_q  <= ctrl_hi;
            en_q  <= ctrl_en;
            rpt_q <= ctrl_rpt;
            if (ctrl_ld) begin
               reload_q <= commit_val;
               count_q  <= commit_val;
            end
         end else if (expire) begin
            if (rpt_q) begin
               count_q <= reload_q;
            end else begin
               count_q <= '0;
               en_q    <= 1'b0;
            end
         end else if (en_q && tick) begin
            count_q <= count_q - EVT_W'(1);
         end
      end
   end

   p_hold_no_tick_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ctrl_we) |=> $stable(count_q));
   p_oneshot_stop_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !rpt_q) |=> !en_q);
   p_reload_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (expire && rpt_q) |=> (en_q && count_q == $past(reload_q)));
endmodule

// File: rtl/dtt_free_counter.sv
module dtt_free_counter #(
   parameter int CNT_W     = 64,
   parameter int WORD_W    = 32,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              lo_rd,
   output logic [WORD_W-1:0] lo_word,
   output logic [WORD_W-1:0] hi_word
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign lo_word = cnt_q[WORD_W-1:0];

   generate
      if (SHADOW_EN) begin : g_shadow
         logic [WORD_W-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hold_q <= '0;
            else if (lo_rd) hold_q <= cnt_q[CNT_W-1:WORD_W];
         end
         assign hi_word = hold_q;
      end else begin : g_direct
         assign hi_word = cnt_q[CNT_W-1:WORD_W];
      end
   endgenerate

   p_free_step_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
   p_free_hold_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
   parameter int BUS_W     = 32,
   parameter int ADDR_W    = 8,
   parameter int EVT_W     = 56,
   parameter int FREE_W    = 64,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   import dtt_pkg::*;

   localparam int HI_W = EVT_W - BUS_W;

   generate
      if (HI_W < 1 || HI_W > CTRL_HI_MAX) begin : g_bad_evt_w
         $error("EVT_W must exceed BUS_W by 1 to 24 bits");
      end
      if (FREE_W != 2 * BUS_W) begin : g_bad_free_w
         $error("FREE_W must be twice BUS_W");
      end
      if (BUS_W <= CTRL_LD_POS || ADDR_W < 6) begin : g_bad_bus
         $error("bus too narrow for the register map");
      end
   endgenerate

   logic hit_lo, hit_ctrl, hit_flo, hit_fhi, hit_mset, hit_mclr, hit_stat;
   assign hit_lo   = (bus_addr == ADDR_W'(OFS_LOAD_LO));
   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_flo  = (bus_addr == ADDR_W'(OFS_FREE_LO));
   assign hit_fhi  = (bus_addr == ADDR_W'(OFS_FREE_HI));
   assign hit_mset = (bus_addr == ADDR_W'(OFS_MSK_SET));
   assign hit_mclr = (bus_addr == ADDR_W'(OFS_MSK_CLR));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));

   logic [BUS_W-1:0] lo_q;
   logic [HI_W-1:0]  hi_q;
   logic             en_q, rpt_q, expire;
   logic [BUS_W-1:0] free_lo, free_hi;
   logic             mask_q, stat_q;

   dtt_event_counter #(.LO_W(BUS_W), .EVT_W(EVT_W)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .lo_we    (bus_we && hit_lo),
      .lo_wdata (bus_wdata),
      .ctrl_we  (bus_we && hit_ctrl),
      .ctrl_hi  (bus_wdata[HI_W-1:0]),
      .ctrl_en  (bus_wdata[CTRL_EN_POS]),
      .ctrl_rpt (bus_wdata[CTRL_RPT_POS]),
      .ctrl_ld  (bus_wdata[CTRL_LD_POS]),
      .lo_q     (lo_q),
      .hi_q     (hi_q),
      .en_q     (en_q),
      .rpt_q    (rpt_q),
      .expire   (expire)
   );

   dtt_free_counter #(.CNT_W(FREE_W), .WORD_W(BUS_W), .SHADOW_EN(SHADOW_EN)) u_free (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .lo_rd   (bus_re && hit_flo),
      .lo_word (free_lo),
      .hi_word (free_hi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b0;
         stat_q <= 1'b0;
      end else begin
         if (bus_we && hit_mset && bus_wdata[0])      mask_q <= 1'b1;
         else if (bus_we && hit_mclr && bus_wdata[0]) mask_q <= 1'b0;
         if (expire)                                  stat_q <= 1'b1;
         else if (bus_we && hit_stat && bus_wdata[0]) stat_q <= 1'b0;
      end
   end

   assign irq = stat_q & mask_q;

   always_comb begin
      bus_rdata = '0;
      if (hit_lo)   bus_rdata = lo_q;
      if (hit_ctrl) begin
         bus_rdata[HI_W-1:0]    = hi_q;
         bus_rdata[CTRL_EN_POS]  = en_q;
         bus_rdata[CTRL_RPT_POS] = rpt_q;
      end
      if (hit_flo)  bus_rdata = free_lo;
      if (hit_fhi)  bus_rdata = free_hi;
      if (hit_mset || hit_mclr) bus_rdata[0] = mask_q;
      if (hit_stat) bus_rdata[0] = stat_q;
   end

   p_status_set_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> stat_q);
   p_mask_clear_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_mclr && bus_wdata[0]) |=> !mask_q);
   p_irq_needs_expiry_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(expire) || $rose(mask_q)));
endmodule

// File: tb/dual_tick_timer_tb_top.sv
module dual_tick_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dual_tick_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 8'h10;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_re = 1'b0; bus_addr = 8'h10;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
      end
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(8'h00, v); check("R1 load", v, 0);
      rd(8'h04, v); check("R1 ctrl", v, 0);
      rd(8'h2C, v); check("R1 mask", v, 0);
      rd(8'h34, v); check("R1 status", v, 0);
      check("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_oneshot;
      logic [31:0] v;
      wr(8'h00, 32'h1234_5678);
      rd(8'h00, v); check("R2 load readback", v, 32'h1234_5678);
      wr(8'h2C, 32'h1);
      wr(8'h00, 32'd5);
      wr(8'h04, 32'h4100_0000);
      ticks(4);
      check("R4 no irq before Nth tick", 32'(irq), 0);
      ticks(1);
      check("R4 irq at Nth tick (R8)", 32'(irq), 1);
      rd(8'h04, v); check("R4 enable cleared", v, 32'h0000_0000);
      wr(8'h34, 32'h0);
      rd(8'h34, v); check("R9 zero write keeps status", v, 1);
      wr(8'h34, 32'h1);
      rd(8'h34, v); check("R9 w1c clears status", v, 0);
      ticks(10);
      check("R4 no second expiry", 32'(irq), 0);
   endtask

   task automatic t_periodic;
      logic [31:0] v;
      wr(8'h00, 32'd3);
      wr(8'h04, 32'h5100_0000);
      ticks(3);
      check("R5 first expiry", 32'(irq), 1);
      wr(8'h34, 32'h1);
      ticks(2);
      check("R5 quiet before reload period", 32'(irq), 0);
      ticks(1);
      check("R5 second expiry", 32'(irq), 1);
      rd(8'h04, v); check("R5 enable kept", v, 32'h1100_0000);
      wr(8'h04, 32'h0);
      wr(8'h34, 32'h1);
      ticks(8);
      rd(8'h34, v); check("R6 stopped timer idle", v, 0);
   endtask

   task automatic t_no_tick;
      logic [31:0] v, f0, f1;
      wr(8'h00, 32'd2);
      wr(8'h04, 32'h4100_0000);
      rd(8'h24, f0);
      repeat (40) @(negedge clk);
      rd(8'h34, v);  check("R12 no expiry without tick", v, 0);
      rd(8'h24, f1); check("R12 free counter holds", f1, f0);
      ticks(2);
      check("R12 expiry after 2 ticks", 32'(irq), 1);
      wr(8'h34, 32'h1);
   endtask

   task automatic t_ctrl_fields;
      logic [31:0] v;
      wr(8'h04, 32'h5100_00AB);
      rd(8'h04, v); check("R3 ctrl readback", v, 32'h1100_00AB);
      wr(8'h04, 32'h0);
      rd(8'h04, v); check("R6 ctrl zero", v, 0);
   endtask

   task automatic t_mask;
      logic [31:0] v;
      wr(8'h00, 32'd1);
      wr(8'h04, 32'h4100_0000);
      ticks(1);
      rd(8'h30, v); check("R7 mask via clear addr", v, 1);
      wr(8'h30, 32'hFFFF_FFFE);
      rd(8'h2C, v); check("R7 zero bit keeps mask", v, 1);
      wr(8'h30, 32'h1);
      rd(8'h2C, v); check("R7 mask cleared", v, 0);
      check("R8 irq off when masked", 32'(irq), 0);
      wr(8'h2C, 32'h1);
      check("R8 irq on when unmasked", 32'(irq), 1);
      wr(8'h34, 32'h1);
   endtask

   task automatic t_free;
      logic [31:0] a, b, h;
      rd(8'h24, a);
      ticks(7);
      rd(8'h24, b); check("R10 low word counts ticks", b, a + 32'd7);
      rd(8'h28, h); check("R10 captured high word", h, 0);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      wr(8'h00, 32'hCAFE_0001);
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      rd(8'h10, v); check("R11 unmapped reads zero", v, 0);
      rd(8'h00, v); check("R11 load untouched", v, 32'hCAFE_0001);
      rd(8'h2C, v); check("R11 mask untouched", v, 1);
      rd(8'h04, v); check("R11 ctrl untouched", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_oneshot;
      t_periodic;
      t_no_tick;
      t_ctrl_fields;
      t_mask;
      t_free;
      t_unmapped;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule